// File: doc/BRIEF.md
# Tuner Synthesizer Control Register Slave

This block is a two-wire serial slave that holds the programming state of a tuner's frequency synthesizer: a 15-bit divider word, a control word (charge-pump current, three test bits, two reference-ratio bits, tuning-output disable) and four band-switch port bits. A host master addresses it with a fixed five-bit prefix followed by two address bits taken from a select input. A write can begin either at the high divider byte or at the control byte, depending on the first data bit. It then steps on through a fixed order of bytes until STOP. Each register takes its new value at the last data clock of the byte that completes it.

A read returns a status byte that reports a sticky power-on flag, the loop-lock flag, the automatic pump-switch flag and a 3-bit converter code. The status byte repeats for as long as the master acknowledges. SCL and SDA are oversampled in the system clock domain, and the slave drives SDA only low, through an output-enable.

Top module: `tuner_i2c_regs`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 1,1,0,0,0,addr_sel[1],addr_sel[0]. It acknowledges by holding SDA low during the ninth clock. It leaves SDA released for any other address.
- R2: In a write, the first data byte selects the entry point by its bit 7. A 0 makes it the high divider byte. A 1 makes it the control byte, and the port byte is then expected next.
- R3: Write bytes advance in the order high divider, low divider, control, port. A byte after the port byte is neither acknowledged nor stored. At most one register commits on any clock.
- R4: The divider output becomes {high byte bits 6:0, low byte bits 7:0} when the low divider byte completes. A high divider byte followed by STOP leaves the divider unchanged.
- R5: When a control byte completes, its bits are stored as follows: bit 6 to cp_high, bits 5:3 to test_mode, bit 2 to ref_sel_a, bit 1 to ref_sel_b and bit 0 to tune_off.
- R6: When a port byte completes, its low nibble is stored and its upper nibble is ignored. port_bits is {uhf, fm, vhf_hi, vhf_lo}. Byte bit 1 is vhf_hi and bit 0 is vhf_lo. With PORT_SWAP=0, bit 3 is fm and bit 2 is uhf. With PORT_SWAP=1, bit 3 is uhf and bit 2 is fm.
- R7: A read sends {por, lock_flag, acp_flag, 1, 1, adc_code[2:0]} MSB first. A further byte is sent after a master acknowledge. After a master non-acknowledge the slave releases SDA.
- R8: The power-on flag reads 1 after reset. It clears once a read ends with a master non-acknowledge, and it stays 0 after that.
- R9: After reset: divider 0, cp_high 1, test_mode 001, ref_sel_a 0, ref_sel_b 1, tune_off 1, port_bits 0, SDA released.
- R10: Data clocked without a preceding START and matching address is not acknowledged and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_sel | input | 2 | Low two slave address bits |
| lock_flag | input | 1 | Loop-lock status |
| acp_flag | input | 1 | Automatic pump-switch status |
| adc_code | input | 3 | Converter code |
| divider | output | 15 | Programmable divider word |
| cp_high | output | 1 | High charge-pump current select |
| test_mode | output | 3 | Test bits |
| ref_sel_a | output | 1 | Reference ratio select A |
| ref_sel_b | output | 1 | Reference ratio select B |
| tune_off | output | 1 | Tuning output disabled |
| port_bits | output | 4 | {uhf, fm, vhf_hi, vhf_lo} |

## Verification
The checks assume that each SCL phase lasts well beyond the synchronizer delay plus a few clocks. They also assume that SDA moves only while SCL is low, except for START and STOP, and that the master never issues STOP while the slave is pulling SDA low. Under those conditions, slave-driven changes land only in SCL-low phases, and registers move only on commit strobes. The bench master uses four-clock quarter periods, changes SDA one quarter after each falling SCL edge, and keeps the status inputs static during every read.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
  localparam int DIV_W = 15;
  localparam int CTL_W = 7;
  localparam int PRT_W = 4;
  localparam logic [4:0] ADDR_PREFIX = 5'b11000;
  localparam logic [CTL_W-1:0] CTL_RESET = 7'b1_001_0_1_1;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WDATA, S_ACK, S_RDATA, S_MACK, S_WAIT
  } slv_state_t;

  typedef enum logic [2:0] {
    W_FIRST, W_DB2, W_CB, W_BB, W_DONE
  } wr_slot_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tuner_fsm.sv
module i2c_tuner_fsm
  import tuner_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [1:0]       addr_sel,
  input  logic [7:0]       status,
  output logic             sda_oe,
  output logic             div_we,
  output logic             ctl_we,
  output logic             prt_we,
  output logic             por_clr,
  output logic [DIV_W-1:0] div_word,
  output logic [CTL_W-1:0] ctl_word,
  output logic [PRT_W-1:0] prt_nib
);
  slv_state_t state;
  wr_slot_t   slot;
  logic [3:0] cnt;
  logic [6:0] sh;
  logic [6:0] tx;
  logic [6:0] div_hi;
  logic       rw, ack_pend, mack;
  logic [7:0] byte_in;
  logic       last_bit;

  assign byte_in  = {sh, sda_s};
  assign last_bit = scl_rise && (cnt == 4'd7);

  assign div_we   = (state == S_WDATA) && last_bit && (slot == W_DB2);
  assign ctl_we   = (state == S_WDATA) && last_bit &&
                    ((slot == W_CB) || (slot == W_FIRST && byte_in[7]));
  assign prt_we   = (state == S_WDATA) && last_bit && (slot == W_BB);
  assign por_clr  = (state == S_MACK) && scl_fall && !mack;
  assign div_word = {div_hi, byte_in};
  assign ctl_word = byte_in[6:0];
  assign prt_nib  = byte_in[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      slot     <= W_DONE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      div_hi   <= '0;
      rw       <= 1'b0;
      ack_pend <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      state  <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_WDATA: begin
          if (scl_rise) begin
            sh  <= byte_in[6:0];
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              if (state == S_ADDR) begin
                ack_pend <= (byte_in[7:1] == {ADDR_PREFIX, addr_sel});
                rw       <= byte_in[0];
                if (byte_in[7:1] == {ADDR_PREFIX, addr_sel} && !byte_in[0])
                  slot <= W_FIRST;
              end else begin
                ack_pend <= (slot != W_DONE);
                case (slot)
                  W_FIRST: begin
                    if (byte_in[7]) slot <= W_BB;
                    else begin
                      div_hi <= byte_in[6:0];
                      slot   <= W_DB2;
                    end
                  end
                  W_DB2:   slot <= W_CB;
                  W_CB:    slot <= W_BB;
                  default: slot <= W_DONE;
                endcase
              end
            end
          end else if (scl_fall && cnt == 4'd8) begin
            if (ack_pend) begin
              sda_oe <= 1'b1;
              state  <= S_ACK;
            end else begin
              state <= S_WAIT;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx     <= status[6:0];
              sda_oe <= ~status[7];
              state  <= S_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_WDATA;
            end
          end
        end
        S_RDATA: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0;
              state  <= S_MACK;
            end else begin
              tx     <= {tx[5:0], 1'b0};
              sda_oe <= ~tx[6];
              cnt    <= cnt + 4'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              tx     <= status[6:0];
              sda_oe <= ~status[7];
              cnt    <= '0;
              state  <= S_RDATA;
            end else begin
              state <= S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tuner_regfile.sv
module tuner_regfile
  import tuner_pkg::*;
#(
  parameter bit PORT_SWAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_word,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic             prt_we,
  input  logic [PRT_W-1:0] prt_nib,
  input  logic             por_clr,
  output logic [DIV_W-1:0] divider,
  output logic [CTL_W-1:0] ctl_q,
  output logic [PRT_W-1:0] port_bits,
  output logic             por
);
  logic [PRT_W-1:0] mapped;

  generate
    if (PORT_SWAP) begin : g_uhf_high
      assign mapped = prt_nib;
    end else begin : g_fm_high
      assign mapped = {prt_nib[2], prt_nib[3], prt_nib[1:0]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divider   <= '0;
      ctl_q     <= CTL_RESET;
      port_bits <= '0;
      por       <= 1'b1;
    end else begin
      if (div_we)  divider   <= div_word;
      if (ctl_we)  ctl_q     <= ctl_word;
      if (prt_we)  port_bits <= mapped;
      if (por_clr) por       <= 1'b0;
    end
  end
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
  import tuner_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit PORT_SWAP   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [1:0]  addr_sel,
  input  logic        lock_flag,
  input  logic        acp_flag,
  input  logic [2:0]  adc_code,
  output logic [14:0] divider,
  output logic        cp_high,
  output logic [2:0]  test_mode,
  output logic        ref_sel_a,
  output logic        ref_sel_b,
  output logic        tune_off,
  output logic [3:0]  port_bits
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic div_we, ctl_we, prt_we, por_clr, por;
  logic [DIV_W-1:0] div_word;
  logic [CTL_W-1:0] ctl_word, ctl_q;
  logic [PRT_W-1:0] prt_nib;
  logic [7:0]       status;

  assign status = {por, lock_flag, acp_flag, 2'b11, adc_code};
  assign {cp_high, test_mode, ref_sel_a, ref_sel_b, tune_off} = ctl_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_s, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det
  );

  i2c_tuner_fsm u_fsm (
    .clk, .rst_n, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det,
    .addr_sel, .status, .sda_oe, .div_we, .ctl_we, .prt_we, .por_clr,
    .div_word, .ctl_word, .prt_nib
  );

  tuner_regfile #(.PORT_SWAP(PORT_SWAP)) u_regs (
    .clk, .rst_n, .div_we, .div_word, .ctl_we, .ctl_word, .prt_we,
    .prt_nib, .por_clr, .divider, .ctl_q, .port_bits, .por
  );
endmodule

// File: rtl/tuner_i2c_regs_chk.sv
module tuner_i2c_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        stop_det,
  input logic        sda_oe,
  input logic        div_we,
  input logic        ctl_we,
  input logic        prt_we,
  input logic        por,
  input logic [14:0] divider,
  input logic        cp_high,
  input logic [2:0]  test_mode,
  input logic        ref_sel_a,
  input logic        ref_sel_b,
  input logic        tune_off,
  input logic [3:0]  port_bits
);
  p_ack_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  p_single_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({div_we, ctl_we, prt_we}));

  p_div_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !div_we |=> $stable(divider));

  p_ctl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable({cp_high, test_mode, ref_sel_a, ref_sel_b, tune_off}));

  p_port_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !prt_we |=> $stable(port_bits));

  p_release_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  p_por_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !por |=> !por);
endmodule

bind tuner_i2c_regs tuner_i2c_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .sda_oe(sda_oe), .div_we(div_we), .ctl_we(ctl_we), .prt_we(prt_we),
  .por(por), .divider(divider), .cp_high(cp_high), .test_mode(test_mode),
  .ref_sel_a(ref_sel_a), .ref_sel_b(ref_sel_b), .tune_off(tune_off),
  .port_bits(port_bits)
);

// File: tb/tuner_i2c_regs_test.sv
module tuner_i2c_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam bit SWAP = 1'b0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [1:0] addr_sel = 2'd0;
  logic lock_flag = 1'b0, acp_flag = 1'b0;
  logic [2:0] adc_code = 3'd0;
  logic [14:0] divider;
  logic cp_high, ref_sel_a, ref_sel_b, tune_off;
  logic [2:0] test_mode;
  logic [3:0] port_bits;

  int total = 0;
  int fails = 0;
  logic [14:0] exp_div;
  logic [6:0]  exp_ctl;
  logic [3:0]  exp_prt;

  assign sda_line = ~(m_low | sda_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  tuner_i2c_regs #(.PORT_SWAP(SWAP)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .lock_flag(lock_flag), .acp_flag(acp_flag),
    .adc_code(adc_code), .divider(divider), .cp_high(cp_high),
    .test_mode(test_mode), .ref_sel_a(ref_sel_a), .ref_sel_b(ref_sel_b),
    .tune_off(tune_off), .port_bits(port_bits)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; m_scl = 1'b1; wclk(Q);
    m_low = 1'b1; wclk(Q);
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; wclk(Q);
    m_scl = 1'b1; wclk(Q);
    m_low = 1'b0; wclk(2*Q);
  endtask

  task automatic bit_clk(input bit b, output bit s);
    wclk(Q); m_low = ~b;
    wclk(Q); m_scl = 1'b1;
    wclk(Q); s = sda_line;
    wclk(Q); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bit_clk(d[i], s);
    bit_clk(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(1'b1, s);
      d[i] = s;
    end
    bit_clk(~give_ack, s);
  endtask

  function automatic logic [3:0] map_ports(input logic [3:0] nib);
    return SWAP ? nib : {nib[2], nib[3], nib[1:0]};
  endfunction

  task automatic check_regs(input string req);
    chk(divider == exp_div, req, 32'(divider), 32'(exp_div));
    chk({cp_high, test_mode, ref_sel_a, ref_sel_b, tune_off} == exp_ctl, req,
        32'({cp_high, test_mode, ref_sel_a, ref_sel_b, tune_off}), 32'(exp_ctl));
    chk(port_bits == exp_prt, req, 32'(port_bits), 32'(exp_prt));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    logic [7:0] exp_sb;
    logic [14:0] n;
    logic [7:0] cb;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);

    // R9 reset state
    exp_div = '0; exp_ctl = 7'b1_001_0_1_1; exp_prt = '0;
    check_regs("R9");
    chk(sda_oe == 1'b0, "R9 sda", 32'(sda_oe), 0);

    // R7 R8 first read with power-on flag still set
    addr_sel = 2'd1; lock_flag = 1'b1; acp_flag = 1'b0; adc_code = 3'd5;
    i2c_start();
    send_byte({5'b11000, 2'd1, 1'b1}, ack);
    chk(ack, "R1 read addr", 32'(ack), 1);
    exp_sb = {1'b1, 1'b1, 1'b0, 2'b11, 3'd5};
    recv_byte(1'b1, rb);
    chk(rb == exp_sb, "R8 por first byte", 32'(rb), 32'(exp_sb));
    recv_byte(1'b0, rb);
    chk(rb == exp_sb, "R7 repeat byte", 32'(rb), 32'(exp_sb));
    wclk(Q);
    chk(sda_oe == 1'b0, "R7 release", 32'(sda_oe), 0);
    i2c_stop();

    // R1 R10 address sweep with control writes
    for (int sel = 0; sel < 4; sel++) begin
      for (int ma = 0; ma < 4; ma++) begin
        addr_sel = 2'(sel);
        cb = {1'b1, 1'(ma), 1'b0, 2'(sel), 1'(ma >> 1), 1'b1, 1'b0};
        i2c_start();
        send_byte({5'b11000, 2'(ma), 1'b0}, ack);
        chk(ack == (sel == ma), "R1 addr ack", 32'(ack), 32'(sel == ma));
        send_byte(cb, ack);
        chk(ack == (sel == ma), (sel == ma) ? "R5 data ack" : "R10 data ack",
            32'(ack), 32'(sel == ma));
        i2c_stop();
        if (sel == ma) exp_ctl = cb[6:0];
        check_regs((sel == ma) ? "R5" : "R10");
      end
    end

    // R10 byte clocked with no START
    begin
      bit s;
      for (int i = 0; i < 8; i++) bit_clk(1'b1, s);
      bit_clk(1'b1, s);
      chk(s == 1'b1, "R10 no start ack", 32'(~s), 0);
      m_low = 1'b0; m_scl = 1'b1; wclk(2*Q);
      check_regs("R10");
    end

    // R2 R4 divider sweep through the low-bit entry
    for (int i = 0; i < 17; i++) begin
      n = (i < 15) ? 15'(1 << i) : ((i == 15) ? 15'h7FFF : 15'h2AD3);
      i2c_start();
      send_byte({5'b11000, 2'd3, 1'b0}, ack);
      send_byte({1'b0, n[14:8]}, ack);
      chk(ack, "R2 db1 ack", 32'(ack), 1);
      send_byte(n[7:0], ack);
      i2c_stop();
      exp_div = n;
      chk(divider == exp_div, "R4 divider", 32'(divider), 32'(exp_div));
    end

    // R4 high byte alone
    i2c_start();
    send_byte({5'b11000, 2'd3, 1'b0}, ack);
    send_byte({1'b0, 7'h55}, ack);
    i2c_stop();
    chk(divider == exp_div, "R4 partial", 32'(divider), 32'(exp_div));

    // R3 full sequence plus extra byte
    i2c_start();
    send_byte({5'b11000, 2'd3, 1'b0}, ack);
    send_byte({1'b0, 7'h12}, ack);
    send_byte(8'h34, ack);
    send_byte({1'b1, 7'b0_110_1_0_0}, ack);
    send_byte(8'hF9, ack);
    chk(ack, "R3 bb ack", 32'(ack), 1);
    send_byte(8'h06, ack);
    chk(!ack, "R3 extra nack", 32'(ack), 0);
    i2c_stop();
    exp_div = 15'h1234; exp_ctl = 7'b0_110_1_0_0; exp_prt = map_ports(4'h9);
    check_regs("R3");

    // R2 R6 control entry then port sweep
    for (int v = 0; v < 16; v++) begin
      cb = {1'b1, 1'b1, 3'(v), 1'b0, 1'(v), 1'b0};
      i2c_start();
      send_byte({5'b11000, 2'd3, 1'b0}, ack);
      send_byte(cb, ack);
      send_byte({~4'(v), 4'(v)}, ack);
      chk(ack, "R2 bb after cb", 32'(ack), 1);
      i2c_stop();
      exp_ctl = cb[6:0];
      exp_prt = map_ports(4'(v));
      chk(port_bits == exp_prt, "R6 ports", 32'(port_bits), 32'(exp_prt));
      chk({cp_high, test_mode, ref_sel_a, ref_sel_b, tune_off} == exp_ctl, "R5 ctl",
          32'({cp_high, test_mode, ref_sel_a, ref_sel_b, tune_off}), 32'(exp_ctl));
      chk(divider == exp_div, "R4 held", 32'(divider), 32'(exp_div));
    end

    // R7 R8 status sweep, flag now cleared
    for (int v = 0; v < 8; v++) begin
      lock_flag = v[0]; acp_flag = v[1]; adc_code = 3'(v);
      i2c_start();
      send_byte({5'b11000, 2'd3, 1'b1}, ack);
      recv_byte(1'b0, rb);
      exp_sb = {1'b0, v[0], v[1], 2'b11, 3'(v)};
      chk(rb == exp_sb, "R7 R8 status", 32'(rb), 32'(exp_sb));
      i2c_stop();
    end

    finish_run();
  end
endmodule